// File: doc/BRIEF.md
# Oldest-First Issue Scheduler Queue

This block sits between an instruction dispatch stage and a set of execution pipes. It accepts one dispatched instruction per clock into a small bounded buffer and holds it there until every source operand is available. It then issues it, out of program order where that helps. Each slot goes through four phases: free, waiting on operands, ready, and issued. An issued slot counts down the instruction's latency. When the count runs out, the slot broadcasts its destination tag to wake any dependent slots, reports a write-back to retirement and frees itself.

Only one instruction issues per cycle, and among the ready slots the one dispatched earliest wins, whatever slot it happens to occupy. Every instruction names a resource group. A per-group round-robin pointer chooses which unit of that group receives it, so that work spreads evenly across identical units. A single write-back port is shared by all slots; when several finish together the oldest reports first. Running statistics track peak occupancy, accumulated occupancy and a two-bin histogram of cycles with and without an issue.

Top module: `oldest_issue_queue`

## Requirements
- R1: A dispatched instruction whose source-ready bits are all set becomes ready on the dispatch edge. One with any bit clear waits until every missing tag has been broadcast.
- R2: If dispatch is accepted on clock edge k, the earliest issue takes place on edge k+1. iss_valid is therefore never high in the cycle right after the dispatch edge.
- R3: A write-back on edge k broadcasts its destination tag on that edge. Any waiting slot with a matching source tag, including a slot being dispatched on edge k, marks that source available, and the dependent instruction can issue on edge k+1.
- R4: At most one instruction issues per edge. It is the ready instruction that was dispatched earliest, independent of slot position.
- R5: An instruction issued on edge k with latency L writes back on edge k+L, so wb_valid and its wb_tag appear L cycles after iss_valid. A latency of 0 behaves as 1.
- R6: Only one write-back is reported per edge. When several issued slots are due together, the one dispatched earliest reports first and each of the others waits one more cycle.
- R7: disp_ready is low exactly when all DEPTH slots are occupied. A dispatch offered while it is low is dropped: that instruction never issues and never writes back.
- R8: Each resource group has its own unit pointer, which is 0 after reset. An issue to a group is reported with the current pointer in iss_unit, and the pointer then advances by one modulo UNITS.
- R9: Statistics are updated on every edge out of reset. st_occ_max is the peak occupancy seen before each edge. st_occ_sum adds that occupancy. st_hist_busy counts edges on which an issue took place, and st_hist_idle counts the rest.
- R10: After reset every slot is free, disp_ready is 1, iss_valid and wb_valid are 0 and all statistics are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_src_tag | input | NSRC*TAG_W | Source tags, source s in bits [s*TAG_W +: TAG_W] |
| disp_src_rdy | input | NSRC | Per-source already-available flags |
| disp_dst_tag | input | TAG_W | Destination tag |
| disp_grp | input | GRP_W | Required resource group |
| disp_lat | input | LAT_W | Execution latency in cycles |
| disp_ready | output | 1 | A free slot exists |
| iss_valid | output | 1 | An instruction issued on the last edge |
| iss_tag | output | TAG_W | Destination tag of the issued instruction |
| iss_grp | output | GRP_W | Resource group of the issued instruction |
| iss_unit | output | UNIT_W | Unit chosen within that group |
| wb_valid | output | 1 | Write-back to retirement |
| wb_tag | output | TAG_W | Tag written back |
| st_occ_max | output | OCC_W | Peak occupancy |
| st_occ_sum | output | SUM_W | Accumulated occupancy |
| st_hist_idle | output | CNT_W | Edges with no issue |
| st_hist_busy | output | CNT_W | Edges with an issue |

## Verification
The bench builds the queue with DEPTH=4, TAG_W=4, two sources, two resource groups of two units each, and 3-bit latency. With only four slots, a single producer and three dependants fill the buffer, so the full and drop behaviour and a wake-up on the same edge as a dispatch can be set up in a few cycles. With two units per group, every step of the round-robin pointer can be observed during a sweep over both groups. Every latency from 0 to 7 is swept, and the exact statistic totals for a short run are worked out by hand.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_WAIT   = 2'd1,
    SLOT_READY  = 2'd2,
    SLOT_ISSUED = 2'd3
  } slot_state_t;
endpackage

// File: rtl/iq_oldest_pick.sv
// Picks the requesting slot with the smallest age rank (0 = oldest).
module iq_oldest_pick #(
  parameter int N  = 4,
  parameter int RW = 2,
  parameter int IW = 2
) (
  input  logic [N-1:0]    req,
  input  logic [N*RW-1:0] rank,
  output logic            found,
  output logic [IW-1:0]   idx
);
  logic [RW-1:0] best;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || rank[i*RW +: RW] < best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = rank[i*RW +: RW];
      end
    end
  end
endmodule

// File: rtl/iq_rr_unit.sv
// Round-robin unit pointer for one resource group.
module iq_rr_unit #(
  parameter int UNITS = 3,
  localparam int UW = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [UW-1:0] unit
);
  localparam logic [UW-1:0] LAST = UW'(UNITS - 1);
  always_ff @(posedge clk) begin
    if (rst)      unit <= '0;
    else if (adv) unit <= (unit == LAST) ? '0 : unit + UW'(1);
  end
endmodule

// File: rtl/iq_stats.sv
// Occupancy and issue statistics, sampled on every edge.
module iq_stats #(
  parameter int OCC_W = 3,
  parameter int SUM_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCC_W-1:0] occ,
  input  logic             issued,
  output logic [OCC_W-1:0] occ_max,
  output logic [SUM_W-1:0] occ_sum,
  output logic [CNT_W-1:0] hist_idle,
  output logic [CNT_W-1:0] hist_busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      occ_max   <= '0;
      occ_sum   <= '0;
      hist_idle <= '0;
      hist_busy <= '0;
    end else begin
      if (occ > occ_max) occ_max <= occ;
      occ_sum <= occ_sum + SUM_W'(occ);
      if (issued) hist_busy <= hist_busy + CNT_W'(1);
      else        hist_idle <= hist_idle + CNT_W'(1);
    end
  end
endmodule

// File: rtl/oldest_issue_queue.sv
module oldest_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int NSRC  = 2,
  parameter int NGRP  = 2,
  parameter int UNITS = 3,
  parameter int LAT_W = 3,
  parameter int SUM_W = 24,
  parameter int CNT_W = 20,
  localparam int GRP_W  = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 disp_valid,
  input  logic [NSRC*TAG_W-1:0] disp_src_tag,
  input  logic [NSRC-1:0]      disp_src_rdy,
  input  logic [TAG_W-1:0]     disp_dst_tag,
  input  logic [GRP_W-1:0]     disp_grp,
  input  logic [LAT_W-1:0]     disp_lat,
  output logic                 disp_ready,
  output logic                 iss_valid,
  output logic [TAG_W-1:0]     iss_tag,
  output logic [GRP_W-1:0]     iss_grp,
  output logic [UNIT_W-1:0]    iss_unit,
  output logic                 wb_valid,
  output logic [TAG_W-1:0]     wb_tag,
  output logic [OCC_W-1:0]     st_occ_max,
  output logic [SUM_W-1:0]     st_occ_sum,
  output logic [CNT_W-1:0]     st_hist_idle,
  output logic [CNT_W-1:0]     st_hist_busy
);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RANK_W = IDX_W;

  // Per-slot storage
  slot_state_t      st      [DEPTH];
  logic [TAG_W-1:0] src_tag [DEPTH][NSRC];
  logic [NSRC-1:0]  src_ok  [DEPTH];
  logic [TAG_W-1:0] dst     [DEPTH];
  logic [GRP_W-1:0] grp     [DEPTH];
  logic [LAT_W-1:0] cnt     [DEPTH];
  logic [RANK_W-1:0] rank   [DEPTH];

  logic [DEPTH-1:0]        ready_vec, done_vec;
  logic [DEPTH*RANK_W-1:0] rank_flat;
  logic [OCC_W-1:0]        n_valid;
  logic                    free_found;
  logic [IDX_W-1:0]        free_idx;
  logic                    iss_found, dn_found;
  logic [IDX_W-1:0]        iss_idx, dn_idx;
  logic [TAG_W-1:0]        bc_tag;
  logic [NSRC-1:0]         src_nxt [DEPTH];
  logic                    disp_fire;
  logic [RANK_W-1:0]       new_rank;
  logic [NGRP-1:0]         rr_adv;
  logic [UNIT_W-1:0]       unit_vec [NGRP];

  always_comb begin
    n_valid    = '0;
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      ready_vec[i] = (st[i] == SLOT_READY);
      done_vec[i]  = (st[i] == SLOT_ISSUED) && (cnt[i] <= LAT_W'(1));
      rank_flat[i*RANK_W +: RANK_W] = rank[i];
      if (st[i] != SLOT_FREE) n_valid = n_valid + OCC_W'(1);
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (st[i] == SLOT_FREE) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign disp_ready = free_found;
  assign disp_fire  = disp_valid && free_found;

  iq_oldest_pick #(.N(DEPTH), .RW(RANK_W), .IW(IDX_W)) u_pick_iss (
    .req(ready_vec), .rank(rank_flat), .found(iss_found), .idx(iss_idx));

  iq_oldest_pick #(.N(DEPTH), .RW(RANK_W), .IW(IDX_W)) u_pick_done (
    .req(done_vec), .rank(rank_flat), .found(dn_found), .idx(dn_idx));

  assign bc_tag   = dst[dn_idx];
  assign new_rank = RANK_W'(n_valid - OCC_W'(dn_found));

  // Source-ready bits after this edge's broadcast (free slots use dispatch inputs)
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      src_nxt[i] = (st[i] == SLOT_FREE) ? disp_src_rdy : src_ok[i];
      for (int s = 0; s < NSRC; s++) begin
        if (dn_found) begin
          if (st[i] == SLOT_FREE) begin
            if (disp_src_tag[s*TAG_W +: TAG_W] == bc_tag) src_nxt[i][s] = 1'b1;
          end else if (src_tag[i][s] == bc_tag) begin
            src_nxt[i][s] = 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_rr
    assign rr_adv[g] = iss_found && (grp[iss_idx] == GRP_W'(g));
    iq_rr_unit #(.UNITS(UNITS)) u_rr (
      .clk(clk), .rst(rst), .adv(rr_adv[g]), .unit(unit_vec[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= SLOT_FREE;
      iss_valid <= 1'b0;
      iss_tag   <= '0;
      iss_grp   <= '0;
      iss_unit  <= '0;
      wb_valid  <= 1'b0;
      wb_tag    <= '0;
    end else begin
      iss_valid <= iss_found;
      wb_valid  <= dn_found;
      if (iss_found) begin
        iss_tag  <= dst[iss_idx];
        iss_grp  <= grp[iss_idx];
        iss_unit <= unit_vec[grp[iss_idx]];
      end
      if (dn_found) wb_tag <= bc_tag;
      for (int i = 0; i < DEPTH; i++) begin
        if (dn_found && st[i] != SLOT_FREE && rank[i] > rank[dn_idx])
          rank[i] <= rank[i] - RANK_W'(1);
        case (st[i])
          SLOT_FREE: begin
            if (disp_fire && free_idx == IDX_W'(i)) begin
              for (int s = 0; s < NSRC; s++)
                src_tag[i][s] <= disp_src_tag[s*TAG_W +: TAG_W];
              src_ok[i] <= src_nxt[i];
              dst[i]    <= disp_dst_tag;
              grp[i]    <= disp_grp;
              cnt[i]    <= (disp_lat == '0) ? LAT_W'(1) : disp_lat;
              rank[i]   <= new_rank;
              st[i]     <= (&src_nxt[i]) ? SLOT_READY : SLOT_WAIT;
            end
          end
          SLOT_WAIT: begin
            src_ok[i] <= src_nxt[i];
            if (&src_nxt[i]) st[i] <= SLOT_READY;
          end
          SLOT_READY: begin
            if (iss_found && iss_idx == IDX_W'(i)) st[i] <= SLOT_ISSUED;
          end
          SLOT_ISSUED: begin
            if (dn_found && dn_idx == IDX_W'(i)) st[i] <= SLOT_FREE;
            else if (cnt[i] > LAT_W'(1))         cnt[i] <= cnt[i] - LAT_W'(1);
          end
          default: st[i] <= SLOT_FREE;
        endcase
      end
    end
  end

  iq_stats #(.OCC_W(OCC_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .occ(n_valid), .issued(iss_found),
    .occ_max(st_occ_max), .occ_sum(st_occ_sum),
    .hist_idle(st_hist_idle), .hist_busy(st_hist_busy));

endmodule

// File: rtl/iq_chk.sv
module iq_chk #(
  parameter int DEPTH  = 8,
  parameter int UNITS  = 3,
  parameter int NGRP   = 2,
  parameter int GRP_W  = 1,
  parameter int UNIT_W = 2,
  parameter int OCC_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic              iss_valid,
  input logic [GRP_W-1:0]  iss_grp,
  input logic [UNIT_W-1:0] iss_unit,
  input logic              wb_valid,
  input logic [OCC_W-1:0]  st_occ_max
);
  localparam logic [UNIT_W-1:0] LAST = UNIT_W'(UNITS - 1);
  logic [OCC_W:0]      acc;
  logic [OCC_W:0]      live;
  logic [UNIT_W-1:0]   nxt_u [NGRP];

  assign live = acc - (OCC_W+1)'(wb_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      for (int g = 0; g < NGRP; g++) nxt_u[g] <= '0;
    end else begin
      acc <= acc + (OCC_W+1)'(disp_valid && disp_ready) - (OCC_W+1)'(wb_valid);
      if (iss_valid)
        nxt_u[iss_grp] <= (iss_unit == LAST) ? '0 : iss_unit + UNIT_W'(1);
    end
  end

  a_r7_full_flag: assert property (@(posedge clk) disable iff (rst)
    !disp_ready |-> live == (OCC_W+1)'(DEPTH));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    live <= (OCC_W+1)'(DEPTH));

  a_r2_dispatch_gap: assert property (@(posedge clk) disable iff (rst)
    (live == '0 && disp_valid && disp_ready) |=> !iss_valid);

  a_r8_round_robin: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> iss_unit == nxt_u[iss_grp]);

  a_r6_wb_has_owner: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> acc != '0);

  a_r9_peak_tracks: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (st_occ_max >= $past(st_occ_max)) && ((OCC_W+1)'(st_occ_max) >= $past(live)));
endmodule

bind oldest_issue_queue iq_chk #(
  .DEPTH(DEPTH), .UNITS(UNITS), .NGRP(NGRP),
  .GRP_W(GRP_W), .UNIT_W(UNIT_W), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .iss_valid(iss_valid), .iss_grp(iss_grp), .iss_unit(iss_unit),
  .wb_valid(wb_valid), .st_occ_max(st_occ_max)
);

// File: tb/oldest_issue_queue_bench.sv
`timescale 1ns/100ps
module oldest_issue_queue_bench;
  localparam int DEPTH = 4, TAG_W = 4, NSRC = 2, NGRP = 2, UNITS = 2, LAT_W = 3;
  localparam int SUM_W = 16, CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid = 1'b0;
  logic [NSRC*TAG_W-1:0] disp_src_tag = '0;
  logic [NSRC-1:0] disp_src_rdy = '0;
  logic [TAG_W-1:0] disp_dst_tag = '0;
  logic disp_grp = 1'b0;
  logic [LAT_W-1:0] disp_lat = '0;
  logic disp_ready, iss_valid, wb_valid;
  logic [TAG_W-1:0] iss_tag, wb_tag;
  logic iss_grp;
  logic iss_unit;
  logic [2:0] st_occ_max;
  logic [SUM_W-1:0] st_occ_sum;
  logic [CNT_W-1:0] st_hist_idle, st_hist_busy;

  oldest_issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NSRC(NSRC), .NGRP(NGRP),
    .UNITS(UNITS), .LAT_W(LAT_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_oldest_issue_queue (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_src_tag(disp_src_tag),
    .disp_src_rdy(disp_src_rdy), .disp_dst_tag(disp_dst_tag), .disp_grp(disp_grp),
    .disp_lat(disp_lat), .disp_ready(disp_ready), .iss_valid(iss_valid),
    .iss_tag(iss_tag), .iss_grp(iss_grp), .iss_unit(iss_unit), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .st_occ_max(st_occ_max), .st_occ_sum(st_occ_sum),
    .st_hist_idle(st_hist_idle), .st_hist_busy(st_hist_busy));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int exp_unit [NGRP];
  int iss_total = 0, bad15 = 0;
  bit ended = 0;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic disp(input logic [3:0] s0, input logic r0, input logic [3:0] s1,
                      input logic r1, input logic [3:0] d, input logic g,
                      input logic [2:0] l);
    disp_src_tag = {s1, s0};
    disp_src_rdy = {r1, r0};
    disp_dst_tag = d;
    disp_grp     = g;
    disp_lat     = l;
    disp_valid   = 1'b1;
    tick();
    disp_valid   = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int g = 0; g < NGRP; g++) exp_unit[g] = 0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  // R8: every issue is checked against an arithmetic round-robin model
  always @(negedge clk) begin
    if (!rst && iss_valid) begin
      chk_eq("R8 unit pick", int'(iss_unit), exp_unit[iss_grp]);
      exp_unit[iss_grp] = (exp_unit[iss_grp] + 1) % UNITS;
      iss_total++;
      if (iss_tag == 4'd15) bad15++;
    end
    if (!rst && wb_valid && wb_tag == 4'd15) bad15++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int m;
    int base;
    do_reset();
    // R10 reset state
    chk_eq("R10 disp_ready", int'(disp_ready), 1);
    chk_eq("R10 iss_valid", int'(iss_valid), 0);
    chk_eq("R10 wb_valid", int'(wb_valid), 0);
    chk_eq("R10 occ_max", int'(st_occ_max), 0);
    chk_eq("R10 occ_sum", int'(st_occ_sum), 0);

    // Scenario A: single ready instruction, latency 2
    disp(4'd0, 1, 4'd0, 1, 4'd3, 0, 3'd2);
    chk_eq("R2 no issue right after dispatch", int'(iss_valid), 0);
    tick();
    chk_eq("R1 ready issues", int'(iss_valid), 1);
    chk_eq("R1 issue tag", int'(iss_tag), 3);
    tick();
    chk_eq("R5 no early wb", int'(wb_valid), 0);
    tick();
    chk_eq("R5 wb at lat", int'(wb_valid), 1);
    chk_eq("R5 wb tag", int'(wb_tag), 3);
    tick();
    chk_eq("R9 occ_sum", int'(st_occ_sum), 3);
    chk_eq("R9 occ_max", int'(st_occ_max), 1);
    chk_eq("R9 hist_busy", int'(st_hist_busy), 1);
    chk_eq("R9 hist_idle", int'(st_hist_idle), 4);

    // R5 latency sweep 0..7
    for (int l = 0; l < 8; l++) begin
      disp(4'd0, 1, 4'd0, 1, 4'(l), 1, 3'(l));
      m = 0;
      while (!iss_valid && m < 20) begin tick(); m++; end
      m = 0;
      do begin tick(); m++; end while (!wb_valid && m < 20);
      chk_eq("R5 latency sweep", m, (l == 0) ? 1 : l);
      tick();
    end

    // Scenario B: dependency wake-up
    disp(4'd0, 1, 4'd0, 1, 4'd5, 0, 3'd3);
    disp(4'd5, 0, 4'd0, 1, 4'd6, 1, 3'd1);
    chk_eq("R3 producer issues", int'(iss_tag), 5);
    tick();
    chk_eq("R1 waiting does not issue", int'(iss_valid), 0);
    tick();
    chk_eq("R1 waiting does not issue", int'(iss_valid), 0);
    tick();
    chk_eq("R3 producer wb", int'(wb_valid && wb_tag == 4'd5), 1);
    chk_eq("R3 no issue on wb edge", int'(iss_valid), 0);
    tick();
    chk_eq("R3 dependant issues next edge", int'(iss_valid && iss_tag == 4'd6), 1);
    repeat (3) tick();

    // Scenario C: oldest-first independent of slot, same-edge capture
    disp(4'd0, 1, 4'd0, 1, 4'd4, 0, 3'd2);   // F slot0
    disp(4'd0, 1, 4'd0, 1, 4'd7, 1, 3'd5);   // P slot1
    disp(4'd7, 0, 4'd0, 1, 4'd1, 0, 3'd1);   // X slot2
    chk_eq("R4 producer issue", int'(iss_valid && iss_tag == 4'd7), 1);
    tick();
    chk_eq("R5 filler wb", int'(wb_valid && wb_tag == 4'd4), 1);
    disp(4'd7, 0, 4'd0, 1, 4'd2, 1, 3'd1);   // Y slot0, younger
    tick();
    tick();
    disp(4'd0, 1, 4'd7, 0, 4'd3, 0, 3'd1);   // V on broadcast edge
    chk_eq("R3 producer wb", int'(wb_valid && wb_tag == 4'd7), 1);
    chk_eq("R4 no issue yet", int'(iss_valid), 0);
    tick();
    chk_eq("R4 oldest first X", int'(iss_tag), 1);
    tick();
    chk_eq("R4 then Y", int'(iss_tag), 2);
    tick();
    chk_eq("R3 same-edge capture V", int'(iss_valid && iss_tag == 4'd3), 1);
    repeat (4) tick();

    // Scenario D: write-back collision
    disp(4'd0, 1, 4'd0, 1, 4'd1, 0, 3'd3);
    disp(4'd0, 1, 4'd0, 1, 4'd2, 0, 3'd2);
    tick();
    tick();
    chk_eq("R6 none before due", int'(wb_valid), 0);
    tick();
    chk_eq("R6 oldest reports first", int'(wb_valid && wb_tag == 4'd1), 1);
    tick();
    chk_eq("R6 younger one cycle later", int'(wb_valid && wb_tag == 4'd2), 1);
    repeat (2) tick();

    // Scenario E: full queue and dropped dispatch
    do_reset();
    disp(4'd0, 1, 4'd0, 1, 4'd9, 1, 3'd6);
    disp(4'd9, 0, 4'd0, 1, 4'd11, 0, 3'd1);
    disp(4'd9, 0, 4'd0, 1, 4'd12, 0, 3'd1);
    disp(4'd0, 1, 4'd9, 0, 4'd13, 1, 3'd1);
    chk_eq("R7 full", int'(disp_ready), 0);
    disp(4'd0, 1, 4'd0, 1, 4'd15, 0, 3'd1);  // dropped
    chk_eq("R7 still full", int'(disp_ready), 0);
    repeat (3) tick();
    chk_eq("R7 slot freed", int'(disp_ready), 1);
    chk_eq("R3 producer wb", int'(wb_valid && wb_tag == 4'd9), 1);
    tick();
    chk_eq("R4 W1", int'(iss_tag), 11);
    tick();
    chk_eq("R4 W2", int'(iss_tag), 12);
    tick();
    chk_eq("R4 W3", int'(iss_tag), 13);
    tick();
    chk_eq("R7 dropped never issues", int'(iss_valid), 0);
    chk_eq("R9 peak occupancy", int'(st_occ_max), 4);
    chk_eq("R9 busy count", int'(st_hist_busy), 4);
    repeat (4) tick();
    chk_eq("R7 dropped tag never seen", bad15, 0);

    // R8 sweep over both groups
    base = iss_total;
    for (int i = 0; i < 16; i++)
      disp(4'd0, 1, 4'd0, 1, 4'(i % 8), 1'((i / 3) % 2), 3'd1);
    repeat (4) tick();
    chk_eq("R8 sweep issue count", iss_total - base, 16);

    finish_up();
  end
endmodule